// File: doc/BRIEF.md
# Device-side invalidation request handler

The handler sits in a device that caches address translations. It takes in invalidation requests. Each request names a page range, an optional process address space identifier, a bitmap of traffic classes and a tag assigned by the root. On acceptance it sends a one-cycle invalidate command to the translation cache. It then holds the request until every read or translation request that was already in flight on the named traffic classes has retired. Work issued after acceptance is not waited for.

Once those transactions have drained, the handler raises a flush request. It waits for the upstream path to confirm that earlier posted writes have gone ahead. It then emits one completion for each traffic class in the bitmap, lowest class first. Every completion in the set carries the request's tag and the size of the set. Up to two requests may be pending. They finish in the order they arrived.

Top module: `atsinv_handler`

## Requirements
- R1: A request is taken on a rising clock edge at which both `inv_valid` and `inv_ready` are high. Its fields are sampled at that edge.
- R2: In the cycle after a request is taken, `cinv_valid` is high for exactly one cycle and carries that request's base, length, PASID enable and PASID. In every other cycle `cinv_valid` is low.
- R3: For each traffic class, a request waits only for the reads still outstanding at the edge it was taken. That count is the number issued minus the number retired before that edge, less any retirement at that edge. Reads issued at or after that edge are not waited for.
- R4: `flush_req` rises one cycle after the oldest pending request has no outstanding reads left to wait for. It stays high until an edge at which `flush_ack` is high.
- R5: No completion is presented before the flush handshake of its request. `cpl_valid` rises in the cycle after the edge at which `flush_req` and `flush_ack` are both high.
- R6: At most two requests are pending at once. `inv_ready` is low exactly while two are pending.
- R7: One completion is sent for each set bit of the traffic class bitmap, in ascending class order. `cpl_tc` gives the class index, where bit n of the bitmap is class n. After a completion is taken, the next class is presented in the following cycle.
- R8: The completions of one request all carry its tag. `cpl_count` equals the number of set bits in the bitmap. An all-zero bitmap is treated as class 0 alone, with a count of 1.
- R9: While `cpl_valid` is high and `cpl_ready` is low, the completion fields hold steady.
- R10: Completion sets leave in the order their requests were taken. A request's last completion being taken frees its slot at that edge.
- R11: After reset, `inv_ready` is high and `cinv_valid`, `flush_req` and `cpl_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid | input | 1 | Invalidation request present |
| inv_ready | output | 1 | Handler can take a request |
| inv_base | input | ADDR_W | Untranslated page base of the range |
| inv_len | input | LEN_W | Range length in pages |
| inv_pasid_en | input | 1 | Request carries a PASID |
| inv_pasid | input | PASID_W | PASID value |
| inv_tc_map | input | NUM_TC | Traffic classes that may have used the range |
| inv_tag | input | TAG_W | Root-assigned tag |
| rd_issue | input | NUM_TC | Per-class pulse: read or translation request issued |
| rd_retire | input | NUM_TC | Per-class pulse: oldest such request retired or nullified |
| cinv_valid | output | 1 | Invalidate command to the cache |
| cinv_base | output | ADDR_W | Range base for the cache |
| cinv_len | output | LEN_W | Range length for the cache |
| cinv_pasid_en | output | 1 | PASID qualifier enable |
| cinv_pasid | output | PASID_W | PASID qualifier |
| flush_req | output | 1 | Request ordering flush of earlier posted writes |
| flush_ack | input | 1 | Flush done |
| cpl_valid | output | 1 | Completion present |
| cpl_ready | input | 1 | Completion taken |
| cpl_tc | output | $clog2(NUM_TC) | Traffic class of this completion |
| cpl_tag | output | TAG_W | Echoed tag |
| cpl_count | output | $clog2(NUM_TC+1) | Number of completions in the set |

## Verification
The handler is driven with several patterns. A lone request with nothing outstanding shows the shortest path from acceptance to completion. Reads are placed on some classes before a request and more after it, which shows whether the wait uses the snapshot taken at acceptance or the live count. Three requests are held back to back while the flush acknowledge is withheld, which exposes the two-entry limit and the ordering of sets. Empty and full bitmaps under a stalling completion consumer separate the count rule, the ascending order and the hold behaviour. A long mixed phase varies issue, retire, acknowledge and ready every cycle against a behavioural model.

// File: rtl/atsinv_pkg.sv
package atsinv_pkg;

    typedef enum logic [1:0] {
        SEQ_DRAIN = 2'd0,
        SEQ_FLUSH = 2'd1,
        SEQ_SEND  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/atsinv_out_track.sv
// Per-class count of read and translation requests in flight.
module atsinv_out_track #(
    parameter int NUM_TC = 8,
    parameter int OUT_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_TC-1:0]              issue,
    input  logic [NUM_TC-1:0]              retire,
    output logic [NUM_TC-1:0][OUT_W-1:0]   cnt
);

    for (genvar t = 0; t < NUM_TC; t++) begin : g_tc
        logic [OUT_W-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (issue[t] && !retire[t]) begin
                cnt_d = cnt_q + OUT_W'(1);
            end else if (!issue[t] && retire[t]) begin
                cnt_d = cnt_q - OUT_W'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign cnt[t] = cnt_q;
    end

endmodule

// File: rtl/atsinv_pend_q.sv
// Pending invalidations: ring of entries, each with a per-class count of
// reads still to retire before the entry may complete.
module atsinv_pend_q #(
    parameter int DEPTH  = 2,
    parameter int NUM_TC = 8,
    parameter int OUT_W  = 8,
    parameter int TAG_W  = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [NUM_TC-1:0]              push_map,
    input  logic [TAG_W-1:0]               push_tag,
    input  logic                           pop,
    input  logic [NUM_TC-1:0]              retire,
    input  logic [NUM_TC-1:0][OUT_W-1:0]   out_cnt,
    output logic                           full,
    output logic                           head_valid,
    output logic                           head_drained,
    output logic [NUM_TC-1:0]              head_map,
    output logic [TAG_W-1:0]               head_tag
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][NUM_TC-1:0]            map;
        logic [DEPTH-1:0][TAG_W-1:0]             tag;
        logic [DEPTH-1:0][NUM_TC-1:0][OUT_W-1:0] rem;
        logic [PTR_W-1:0]                        wr;
        logic [PTR_W-1:0]                        rd;
        logic [OCC_W-1:0]                        occ;
    } q_t;

    q_t q_d, q_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        q_d = q_q;
        // retirements count down every entry still waiting on that class
        for (int e = 0; e < DEPTH; e++) begin
            for (int t = 0; t < NUM_TC; t++) begin
                if (retire[t] && (q_q.rem[e][t] != '0)) begin
                    q_d.rem[e][t] = q_q.rem[e][t] - OUT_W'(1);
                end
            end
        end
        if (push) begin
            q_d.map[q_q.wr] = push_map;
            q_d.tag[q_q.wr] = push_tag;
            for (int t = 0; t < NUM_TC; t++) begin
                q_d.rem[q_q.wr][t] = out_cnt[t] - OUT_W'(retire[t]);
            end
            q_d.wr = ptr_inc(q_q.wr);
        end
        if (pop) begin
            q_d.rd = ptr_inc(q_q.rd);
        end
        case ({push, pop})
            2'b10:   q_d.occ = q_q.occ + OCC_W'(1);
            2'b01:   q_d.occ = q_q.occ - OCC_W'(1);
            default: q_d.occ = q_q.occ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    always_comb begin
        head_drained = 1'b1;
        for (int t = 0; t < NUM_TC; t++) begin
            if (q_q.rem[q_q.rd][t] != '0) begin
                head_drained = 1'b0;
            end
        end
    end

    assign full       = (q_q.occ == OCC_W'(DEPTH));
    assign head_valid = (q_q.occ != '0);
    assign head_map   = q_q.map[q_q.rd];
    assign head_tag   = q_q.tag[q_q.rd];

endmodule

// File: rtl/atsinv_cpl_seq.sv
// Head sequencer: wait for drain, flush handshake, then one completion per
// class in ascending order.
module atsinv_cpl_seq #(
    parameter int NUM_TC = 8,
    parameter int TAG_W  = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          head_valid,
    input  logic                          head_drained,
    input  logic [NUM_TC-1:0]             head_map,
    input  logic [TAG_W-1:0]              head_tag,
    output logic                          flush_req,
    input  logic                          flush_ack,
    output logic                          cpl_valid,
    input  logic                          cpl_ready,
    output logic [$clog2(NUM_TC)-1:0]     cpl_tc,
    output logic [TAG_W-1:0]              cpl_tag,
    output logic [$clog2(NUM_TC+1)-1:0]   cpl_count,
    output logic                          pop
);
    import atsinv_pkg::*;

    localparam int TCI_W = $clog2(NUM_TC);
    localparam int CNT_W = $clog2(NUM_TC + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [TCI_W-1:0] ptr;
    } seq_t;

    seq_t s_d, s_q;

    logic [NUM_TC-1:0] eff_map;
    logic [TCI_W-1:0]  first_tc;
    logic [TCI_W-1:0]  next_tc;
    logic              has_next;
    logic [CNT_W-1:0]  set_size;

    assign eff_map = (head_map == '0) ? NUM_TC'(1) : head_map;

    always_comb begin
        first_tc = '0;
        next_tc  = '0;
        has_next = 1'b0;
        set_size = '0;
        for (int t = NUM_TC - 1; t >= 0; t--) begin
            if (eff_map[t]) begin
                first_tc = TCI_W'(t);
                if (t > int'(s_q.ptr)) begin
                    next_tc  = TCI_W'(t);
                    has_next = 1'b1;
                end
            end
        end
        for (int t = 0; t < NUM_TC; t++) begin
            set_size = set_size + CNT_W'(eff_map[t]);
        end
    end

    always_comb begin
        s_d = s_q;
        pop = 1'b0;
        case (s_q.st)
            SEQ_DRAIN: begin
                if (head_valid && head_drained) begin
                    s_d.st = SEQ_FLUSH;
                end
            end
            SEQ_FLUSH: begin
                if (flush_ack) begin
                    s_d.st  = SEQ_SEND;
                    s_d.ptr = first_tc;
                end
            end
            SEQ_SEND: begin
                if (cpl_ready) begin
                    if (has_next) begin
                        s_d.ptr = next_tc;
                    end else begin
                        pop    = 1'b1;
                        s_d.st = SEQ_DRAIN;
                    end
                end
            end
            default: s_d.st = SEQ_DRAIN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_DRAIN, ptr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign flush_req = (s_q.st == SEQ_FLUSH);
    assign cpl_valid = (s_q.st == SEQ_SEND);
    assign cpl_tc    = s_q.ptr;
    assign cpl_tag   = head_tag;
    assign cpl_count = set_size;

endmodule

// File: rtl/atsinv_handler.sv
module atsinv_handler #(
    parameter int NUM_TC  = 8,
    parameter int DEPTH   = 2,
    parameter int OUT_W   = 8,
    parameter int ADDR_W  = 52,
    parameter int LEN_W   = 16,
    parameter int PASID_W = 20,
    parameter int TAG_W   = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          inv_valid,
    output logic                          inv_ready,
    input  logic [ADDR_W-1:0]             inv_base,
    input  logic [LEN_W-1:0]              inv_len,
    input  logic                          inv_pasid_en,
    input  logic [PASID_W-1:0]            inv_pasid,
    input  logic [NUM_TC-1:0]             inv_tc_map,
    input  logic [TAG_W-1:0]              inv_tag,
    input  logic [NUM_TC-1:0]             rd_issue,
    input  logic [NUM_TC-1:0]             rd_retire,
    output logic                          cinv_valid,
    output logic [ADDR_W-1:0]             cinv_base,
    output logic [LEN_W-1:0]              cinv_len,
    output logic                          cinv_pasid_en,
    output logic [PASID_W-1:0]            cinv_pasid,
    output logic                          flush_req,
    input  logic                          flush_ack,
    output logic                          cpl_valid,
    input  logic                          cpl_ready,
    output logic [$clog2(NUM_TC)-1:0]     cpl_tc,
    output logic [TAG_W-1:0]              cpl_tag,
    output logic [$clog2(NUM_TC+1)-1:0]   cpl_count
);

    typedef struct packed {
        logic               vld;
        logic [ADDR_W-1:0]  base;
        logic [LEN_W-1:0]   len;
        logic               pen;
        logic [PASID_W-1:0] pasid;
    } cinv_t;

    cinv_t c_d, c_q;

    logic                         full;
    logic                         take;
    logic                         pop;
    logic                         head_valid;
    logic                         head_drained;
    logic [NUM_TC-1:0]            head_map;
    logic [TAG_W-1:0]             head_tag;
    logic [NUM_TC-1:0][OUT_W-1:0] out_cnt;

    assign inv_ready = !full;
    assign take      = inv_valid && inv_ready;

    atsinv_out_track #(.NUM_TC(NUM_TC), .OUT_W(OUT_W)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .issue  (rd_issue),
        .retire (rd_retire),
        .cnt    (out_cnt)
    );

    atsinv_pend_q #(.DEPTH(DEPTH), .NUM_TC(NUM_TC), .OUT_W(OUT_W), .TAG_W(TAG_W)) u_pend (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (take),
        .push_map     (inv_tc_map),
        .push_tag     (inv_tag),
        .pop          (pop),
        .retire       (rd_retire),
        .out_cnt      (out_cnt),
        .full         (full),
        .head_valid   (head_valid),
        .head_drained (head_drained),
        .head_map     (head_map),
        .head_tag     (head_tag)
    );

    atsinv_cpl_seq #(.NUM_TC(NUM_TC), .TAG_W(TAG_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .head_valid   (head_valid),
        .head_drained (head_drained),
        .head_map     (head_map),
        .head_tag     (head_tag),
        .flush_req    (flush_req),
        .flush_ack    (flush_ack),
        .cpl_valid    (cpl_valid),
        .cpl_ready    (cpl_ready),
        .cpl_tc       (cpl_tc),
        .cpl_tag      (cpl_tag),
        .cpl_count    (cpl_count),
        .pop          (pop)
    );

    always_comb begin
        c_d     = c_q;
        c_d.vld = take;
        if (take) begin
            c_d.base  = inv_base;
            c_d.len   = inv_len;
            c_d.pen   = inv_pasid_en;
            c_d.pasid = inv_pasid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cinv_valid    = c_q.vld;
    assign cinv_base     = c_q.base;
    assign cinv_len      = c_q.len;
    assign cinv_pasid_en = c_q.pen;
    assign cinv_pasid    = c_q.pasid;

endmodule

// File: rtl/atsinv_chk.sv
module atsinv_chk #(
    parameter int NUM_TC = 8,
    parameter int TAG_W  = 5
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          inv_valid,
    input logic                          inv_ready,
    input logic                          cinv_valid,
    input logic                          flush_req,
    input logic                          flush_ack,
    input logic                          cpl_valid,
    input logic                          cpl_ready,
    input logic [$clog2(NUM_TC)-1:0]     cpl_tc,
    input logic [TAG_W-1:0]              cpl_tag,
    input logic [$clog2(NUM_TC+1)-1:0]   cpl_count
);

    // R2
    cinv_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_ready) |=> cinv_valid);

    // R2
    cinv_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_valid && inv_ready) |=> !cinv_valid);

    // R4
    flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_ack) |=> flush_req);

    // R5
    cpl_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpl_valid) |-> $past(flush_req && flush_ack));

    // R9
    cpl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=>
            (cpl_valid && $stable(cpl_tc) && $stable(cpl_tag) && $stable(cpl_count)));

    // R7
    cpl_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |=> (!cpl_valid || (cpl_tc > $past(cpl_tc))));

    // R8
    cpl_same_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |=> (!cpl_valid || ($stable(cpl_tag) && $stable(cpl_count))));

    // R8
    cpl_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> ((cpl_count != '0) && (int'(cpl_count) <= NUM_TC)));

endmodule

bind atsinv_handler atsinv_chk #(.NUM_TC(NUM_TC), .TAG_W(TAG_W)) chk_i (.*);

// File: tb/atsinv_handler_tb_top.sv
module atsinv_handler_tb_top;

    localparam int NTC = 8;
    localparam int AW  = 52;
    localparam int LW  = 16;
    localparam int PW  = 20;
    localparam int TW  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic           inv_valid = 1'b0;
    logic           inv_ready;
    logic [AW-1:0]  inv_base = '0;
    logic [LW-1:0]  inv_len = '0;
    logic           inv_pasid_en = 1'b0;
    logic [PW-1:0]  inv_pasid = '0;
    logic [NTC-1:0] inv_tc_map = '0;
    logic [TW-1:0]  inv_tag = '0;
    logic [NTC-1:0] rd_issue = '0;
    logic [NTC-1:0] rd_retire = '0;
    logic           cinv_valid;
    logic [AW-1:0]  cinv_base;
    logic [LW-1:0]  cinv_len;
    logic           cinv_pasid_en;
    logic [PW-1:0]  cinv_pasid;
    logic           flush_req;
    logic           flush_ack = 1'b0;
    logic           cpl_valid;
    logic           cpl_ready = 1'b1;
    logic [2:0]     cpl_tc;
    logic [TW-1:0]  cpl_tag;
    logic [3:0]     cpl_count;

    atsinv_handler dut_i (.*);

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // behavioural reference state
    int             m_cnt;
    logic [NTC-1:0] m_map [2];
    logic [TW-1:0]  m_tag [2];
    int             m_rem [2][NTC];
    int             m_out [NTC];
    int             m_st;
    int             m_ptr;
    bit             e_cv;
    logic [AW-1:0]  e_base;
    logic [LW-1:0]  e_len;
    logic           e_pen;
    logic [PW-1:0]  e_pasid;
    bit             acc_last;
    bit             acc, pop;
    int             nb;

    function automatic logic [NTC-1:0] effm(input logic [NTC-1:0] m);
        return (m == '0) ? NTC'(1) : m;
    endfunction

    function automatic int popc(input logic [NTC-1:0] m);
        int c = 0;
        for (int i = 0; i < NTC; i++) if (m[i]) c++;
        return c;
    endfunction

    function automatic int bit_above(input logic [NTC-1:0] m, input int from);
        for (int i = from + 1; i < NTC; i++) if (m[i]) return i;
        return -1;
    endfunction

    function automatic bit head_clear();
        for (int i = 0; i < NTC; i++) if (m_rem[0][i] != 0) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_st = 0; m_ptr = 0; e_cv = 0; acc_last = 0;
            for (int t = 0; t < NTC; t++) begin
                m_out[t] = 0; m_rem[0][t] = 0; m_rem[1][t] = 0;
            end
        end else begin
            acc = inv_valid && (m_cnt < 2);
            pop = 1'b0;
            case (m_st)
                0: if (m_cnt > 0 && head_clear()) m_st = 1;
                1: if (flush_ack) begin m_st = 2; m_ptr = bit_above(effm(m_map[0]), -1); end
                default: if (cpl_ready) begin
                    nb = bit_above(effm(m_map[0]), m_ptr);
                    if (nb >= 0) m_ptr = nb;
                    else begin pop = 1'b1; m_st = 0; end
                end
            endcase
            for (int e = 0; e < m_cnt; e++)
                for (int t = 0; t < NTC; t++)
                    if (rd_retire[t] && m_rem[e][t] > 0) m_rem[e][t]--;
            if (pop) begin
                m_map[0] = m_map[1]; m_tag[0] = m_tag[1];
                for (int t = 0; t < NTC; t++) m_rem[0][t] = m_rem[1][t];
                m_cnt--;
            end
            if (acc) begin
                m_map[m_cnt] = inv_tc_map; m_tag[m_cnt] = inv_tag;
                for (int t = 0; t < NTC; t++) m_rem[m_cnt][t] = m_out[t] - int'(rd_retire[t]);
                m_cnt++;
                e_base = inv_base; e_len = inv_len; e_pen = inv_pasid_en; e_pasid = inv_pasid;
            end
            for (int t = 0; t < NTC; t++) m_out[t] += int'(rd_issue[t]) - int'(rd_retire[t]);
            e_cv = acc;
            acc_last = acc;
        end
    end

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", r, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 inv_ready", 64'(inv_ready), 64'(m_cnt < 2));
            chk("R1/R2 cinv_valid", 64'(cinv_valid), 64'(e_cv));
            if (e_cv) begin
                chk("R2 cinv_base", 64'(cinv_base), 64'(e_base));
                chk("R2 cinv_len", 64'(cinv_len), 64'(e_len));
                chk("R2 cinv_pasid", 64'({cinv_pasid_en, cinv_pasid}), 64'({e_pen, e_pasid}));
            end
            chk("R3/R4 flush_req", 64'(flush_req), 64'(m_st == 1));
            chk("R5 cpl_valid", 64'(cpl_valid), 64'(m_st == 2));
            if (m_st == 2) begin
                chk("R7/R9 cpl_tc", 64'(cpl_tc), 64'(m_ptr));
                chk("R8/R10 cpl_tag", 64'(cpl_tag), 64'(m_tag[0]));
                chk("R8 cpl_count", 64'(cpl_count), 64'(popc(effm(m_map[0]))));
            end
        end
    end

    task automatic summary();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_inv(input logic [NTC-1:0] map, input logic [TW-1:0] tag);
        inv_tc_map = map; inv_tag = tag;
        inv_base = {$urandom, $urandom}; inv_len = LW'($urandom);
        inv_pasid_en = 1'($urandom); inv_pasid = PW'($urandom);
        inv_valid = 1'b1;
        do @(negedge clk); while (!acc_last);
        inv_valid = 1'b0;
    endtask

    task automatic pulse(input bit is_issue, input int tc);
        if (is_issue) rd_issue = NTC'(1) << tc; else rd_retire = NTC'(1) << tc;
        @(negedge clk);
        rd_issue = '0; rd_retire = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 inv_ready", 64'(inv_ready), 64'd1);
        chk("R11 cinv_valid", 64'(cinv_valid), 64'd0);
        chk("R11 flush_req", 64'(flush_req), 64'd0);
        chk("R11 cpl_valid", 64'(cpl_valid), 64'd0);
        rst_n = 1'b1;
        idle(2);

        // R1 R2 R7 R8: lone request, nothing outstanding
        flush_ack = 1'b1;
        send_inv(8'b0000_0101, 5'd3);
        idle(8);

        // R3 R4 R5: wait only on reads in flight at acceptance
        flush_ack = 1'b0;
        for (int i = 0; i < 3; i++) pulse(1'b1, 1);
        for (int i = 0; i < 2; i++) pulse(1'b1, 4);
        send_inv(8'b0001_0010, 5'd9);
        pulse(1'b1, 1); pulse(1'b1, 1);
        idle(2);
        for (int i = 0; i < 3; i++) begin pulse(1'b0, 1); idle(1); end
        pulse(1'b0, 4); idle(2); pulse(1'b0, 4);
        idle(6);
        flush_ack = 1'b1;
        pulse(1'b0, 1); pulse(1'b0, 1);
        idle(8);

        // R6 R10: three back to back, flush withheld
        flush_ack = 1'b0;
        send_inv(8'h81, 5'd11);
        send_inv(8'h40, 5'd12);
        fork
            send_inv(8'h06, 5'd13);
            begin idle(5); flush_ack = 1'b1; end
        join
        idle(20);

        // R8 R9: empty map, then all classes with a stalling consumer
        send_inv(8'h00, 5'd20);
        idle(8);
        send_inv(8'hFF, 5'd21);
        for (int i = 0; i < 30; i++) begin
            cpl_ready = (i % 3 == 0);
            @(negedge clk);
        end
        cpl_ready = 1'b1;
        idle(6);

        // R3 R7 R10: mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            inv_valid    = ($urandom % 8 == 0);
            inv_tc_map   = NTC'($urandom);
            inv_tag      = TW'($urandom);
            inv_base     = {$urandom, $urandom};
            inv_len      = LW'($urandom);
            inv_pasid_en = 1'($urandom);
            inv_pasid    = PW'($urandom);
            for (int t = 0; t < NTC; t++) begin
                rd_issue[t]  = (m_out[t] < 100) && ($urandom % 4 == 0);
                rd_retire[t] = (m_out[t] > 0) && ($urandom % 3 == 0);
            end
            flush_ack = 1'($urandom);
            cpl_ready = ($urandom % 4 != 0);
            @(negedge clk);
        end
        inv_valid = 1'b0; rd_issue = '0;
        flush_ack = 1'b1; cpl_ready = 1'b1;
        for (int i = 0; i < 400; i++) begin
            for (int t = 0; t < NTC; t++) rd_retire[t] = (m_out[t] > 0);
            @(negedge clk);
        end
        rd_retire = '0;
        idle(20);
        summary();
    end

endmodule